// File: doc/BRIEF.md
# Multiplexed Asynchronous Memory Read Sequencer

This block is a bus master that performs single read transfers from an external asynchronous PSRAM or NOR device. The device shares one bus for the low address bits and the data. A host raises a request with an address and byte-lane enables. The sequencer then runs a fixed three-cycle access. In the first cycle the low address is latched into the device with an address-valid strobe. In the second cycle the address is still held on the bus. In the third cycle the bus is released and the device is read with output enable.

The read word is captured on the edge that closes the access. It is presented to the host with a one-cycle valid pulse and then held. Every phase length is counted in system clock cycles and fixed in the logic. The memory-side strobes are active low and idle high.

The pad on the shared bus is split into an outgoing value (`ad_o`), a drive enable (`ad_oe_o`) and an incoming value (`ad_i`).

Top module: `mux_rd_seq`

## Requirements
- R1: After a request is accepted on a clock edge, `ce_n_o` is low for exactly the next three cycles (cycles 1 to 3 of the transfer) and high otherwise.
- R2: `oe_n_o` is low only in cycle 3 of a transfer and high in every other cycle.
- R3: `oe_n_o` and `ce_n_o` rise on the same clock edge, the one that ends cycle 3.
- R4: `adv_n_o` is low only in cycle 1 of a transfer, together with the falling `ce_n_o`.
- R5: In cycles 1 and 2, `ad_oe_o` is 1 and `ad_o` carries `addr_i[15:0]`. From cycle 3 on, and whenever idle, `ad_oe_o` is 0.
- R6: `addr_hi_o` carries `addr_i[25:16]` from cycle 1 through cycle 4 (the cycle after output enable rises). `bl_n_o` is the bitwise inverse of `be_i` in cycles 1 to 3 and all ones otherwise.
- R7: `ad_i` is sampled on the edge that ends cycle 3. In cycle 4 it appears on `rdata_o` while `rvalid_o` is 1 for that cycle only. `rdata_o` then holds its value until the next transfer completes.
- R8: `we_n_o` is high in every cycle.
- R9: During and right after reset all strobes are high, `bl_n_o` is all ones, and `ad_oe_o`, `busy_o` and `rvalid_o` are 0.
- R10: A request is accepted only on an edge where the sequencer is idle. A request raised while busy changes no output of the running transfer.
- R11: `busy_o` is 1 from cycle 1 through cycle 4 (the valid cycle) and 0 when idle.
- R12: Between two transfers `ce_n_o` is high for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request strobe |
| addr_i | input | 26 | Read address |
| be_i | input | 2 | Byte-lane enables, active high |
| busy_o | output | 1 | Transfer in progress |
| rdata_o | output | 16 | Read data, held after capture |
| rvalid_o | output | 1 | One-cycle read data valid pulse |
| ce_n_o | output | 1 | Chip enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low, always inactive |
| adv_n_o | output | 1 | Address-valid strobe, active low |
| addr_hi_o | output | 10 | Upper address lines |
| bl_n_o | output | 2 | Byte-lane lines, active low |
| ad_o | output | 16 | Shared bus outgoing value |
| ad_oe_o | output | 1 | Shared bus drive enable |
| ad_i | input | 16 | Shared bus incoming value |

## Verification
The assertions assume that `req_i`, `addr_i` and `be_i` are stable around the clock edge. They also assume that the device drives the bus only while output enable is low. They place no limit on when the host raises a request, so requests raised while busy must leave the running transfer untouched.

The bench drives all inputs on the falling edge. Its memory model returns the expected word only while `oe_n_o` is low and the inverted word otherwise, so a capture on the wrong edge shows up as a wrong value. Seeded random addresses, lane enables, data, idle gaps and requests raised while busy are mixed with directed all-zero and all-one cases.

// File: rtl/mux_rd_pkg.sv
package mux_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADR,
    ST_HLD,
    ST_RD,
    ST_FIN
  } st_e;

  // internal phase flags, active high
  typedef struct packed {
    logic ce;
    logic adv;
    logic oe;
    logic drive;
    logic lanes;
    logic cap;
  } ph_t;

endpackage

// File: rtl/mux_rd_fsm.sv
module mux_rd_fsm
  import mux_rd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic accept_o,
  output logic busy_o,
  output ph_t  ph_o
);

  st_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_ADR;
      ST_ADR:  state_d = ST_HLD;
      ST_HLD:  state_d = ST_RD;
      ST_RD:   state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    ph_o       = '0;
    ph_o.ce    = (state_q == ST_ADR) || (state_q == ST_HLD) || (state_q == ST_RD);
    ph_o.adv   = (state_q == ST_ADR);
    ph_o.oe    = (state_q == ST_RD);
    ph_o.drive = (state_q == ST_ADR) || (state_q == ST_HLD);
    ph_o.lanes = ph_o.ce;
    ph_o.cap   = (state_q == ST_RD);
  end

  assign busy_o = (state_q != ST_IDLE);

  p_ce_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph_o.ce) |=> ph_o.ce ##1 ph_o.ce ##1 !ph_o.ce);

  p_oe_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph_o.ce) |-> !ph_o.oe ##1 !ph_o.oe ##1 ph_o.oe ##1 !ph_o.oe);

  p_rise_together_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_o.oe) |-> $fell(ph_o.ce));

  p_adv_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_o.adv |-> $rose(ph_o.ce));

  p_accept_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph_o.ce) |-> $past(state_q == ST_IDLE && req_i));

  p_busy_cover_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_o.ce |-> busy_o);

  p_gap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ph_o.ce) |=> !ph_o.ce);

endmodule

// File: rtl/mux_rd_addr.sv
module mux_rd_addr #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BE_W   = 2,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              adv_i,
  input  logic              oe_i,
  input  logic              drive_i,
  input  logic              lanes_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [BE_W-1:0]   bl_n_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      be_q   <= '0;
    end else if (accept_i) begin
      addr_q <= addr_i;
      be_q   <= be_i;
    end
  end

  assign ad_oe_o   = drive_i;
  assign ad_o      = drive_i ? addr_q[DATA_W-1:0] : '0;
  // upper lines keep the latched value until the next accept
  assign addr_hi_o = addr_q[ADDR_W-1:DATA_W];

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign bl_n_o[g] = !(lanes_i && be_q[g]);
  end

  p_lo_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adv_i) |-> ad_oe_o && $stable(ad_o));

  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> !ad_oe_o);

  p_hi_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_i) |-> $stable(addr_hi_o));

  p_lanes_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lanes_i |-> (&bl_n_o));

endmodule

// File: rtl/mux_rd_capture.sv
module mux_rd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              oe_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= ad_i;
    end
  end

  p_valid_after_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(oe_i) && !oe_i);

  p_data_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> $stable(rdata_o));

endmodule

// File: rtl/mux_rd_seq.sv
module mux_rd_seq
  import mux_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BE_W   = 2,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic              adv_n_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [BE_W-1:0]   bl_n_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i
);

  ph_t  ph;
  logic accept;

  mux_rd_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .ph_o     (ph)
  );

  mux_rd_addr #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (addr_i),
    .be_i      (be_i),
    .adv_i     (ph.adv),
    .oe_i      (ph.oe),
    .drive_i   (ph.drive),
    .lanes_i   (ph.lanes),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .addr_hi_o (addr_hi_o),
    .bl_n_o    (bl_n_o)
  );

  mux_rd_capture #(
    .DATA_W (DATA_W)
  ) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (ph.cap),
    .oe_i     (ph.oe),
    .ad_i     (ad_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign ce_n_o  = !ph.ce;
  assign oe_n_o  = !ph.oe;
  assign adv_n_o = !ph.adv;
  assign we_n_o  = 1'b1;

  p_valid_in_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> busy_o && ce_n_o);

endmodule

// File: tb/mux_rd_seq_bench.sv
module mux_rd_seq_bench;

  localparam int ADDR_W = 26;
  localparam int DATA_W = 16;
  localparam int BE_W   = 2;
  localparam int HI_W   = ADDR_W - DATA_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [BE_W-1:0]   be = '0;
  logic              busy, rvalid, ce_n, oe_n, we_n, adv_n, ad_oe;
  logic [DATA_W-1:0] rdata, ad_o, ad_i, mem_data;
  logic [HI_W-1:0]   addr_hi;
  logic [BE_W-1:0]   bl_n;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = !clk;

  // device model: valid word only while output enable is low
  assign ad_i = oe_n ? ~mem_data : mem_data;

  mux_rd_seq u_mux_rd_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .be_i(be),
    .busy_o(busy), .rdata_o(rdata), .rvalid_o(rvalid), .ce_n_o(ce_n),
    .oe_n_o(oe_n), .we_n_o(we_n), .adv_n_o(adv_n), .addr_hi_o(addr_hi),
    .bl_n_o(bl_n), .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i)
  );

  function automatic logic [DATA_W-1:0] exp_lo(input logic [ADDR_W-1:0] a);
    return a[DATA_W-1:0];
  endfunction
  function automatic logic [HI_W-1:0] exp_hi(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:DATA_W];
  endfunction
  function automatic logic [BE_W-1:0] exp_bl(input logic [BE_W-1:0] b);
    return ~b;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input logic [DATA_W-1:0] held);
    chk("R12 ce high idle", 32'(ce_n), 32'd1);
    chk("R2 oe high idle", 32'(oe_n), 32'd1);
    chk("R8 we high", 32'(we_n), 32'd1);
    chk("R5 bus released idle", 32'(ad_oe), 32'd0);
    chk("R11 busy low idle", 32'(busy), 32'd0);
    chk("R7 data held", 32'(rdata), 32'(held));
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [BE_W-1:0] b,
                         input logic [DATA_W-1:0] d, input bit poke, input int gap);
    @(negedge clk);
    req = 1'b1; addr = a; be = b; mem_data = d;
    @(negedge clk); // cycle 1
    chk("R1 ce low c1", 32'(ce_n), 32'd0);
    chk("R4 adv low c1", 32'(adv_n), 32'd0);
    chk("R2 oe high c1", 32'(oe_n), 32'd1);
    chk("R5 drive c1", 32'(ad_oe), 32'd1);
    chk("R5 lo addr c1", 32'(ad_o), 32'(exp_lo(a)));
    chk("R6 hi addr c1", 32'(addr_hi), 32'(exp_hi(a)));
    chk("R6 lanes c1", 32'(bl_n), 32'(exp_bl(b)));
    chk("R11 busy c1", 32'(busy), 32'd1);
    chk("R8 we c1", 32'(we_n), 32'd1);
    if (poke) begin
      req = 1'b1; addr = ~a; be = ~b;
    end else begin
      req = 1'b0;
    end
    @(negedge clk); // cycle 2
    chk("R1 ce low c2", 32'(ce_n), 32'd0);
    chk("R4 adv high c2", 32'(adv_n), 32'd1);
    chk("R2 oe high c2", 32'(oe_n), 32'd1);
    chk("R5 drive c2", 32'(ad_oe), 32'd1);
    chk("R10 R5 lo addr c2", 32'(ad_o), 32'(exp_lo(a)));
    chk("R10 R6 hi addr c2", 32'(addr_hi), 32'(exp_hi(a)));
    @(negedge clk); // cycle 3
    chk("R1 ce low c3", 32'(ce_n), 32'd0);
    chk("R2 oe low c3", 32'(oe_n), 32'd0);
    chk("R4 adv high c3", 32'(adv_n), 32'd1);
    chk("R5 released c3", 32'(ad_oe), 32'd0);
    chk("R10 R6 lanes c3", 32'(bl_n), 32'(exp_bl(b)));
    chk("R7 no valid c3", 32'(rvalid), 32'd0);
    @(negedge clk); // cycle 4
    req = 1'b0;
    chk("R1 R3 ce high c4", 32'(ce_n), 32'd1);
    chk("R3 oe high c4", 32'(oe_n), 32'd1);
    chk("R7 valid c4", 32'(rvalid), 32'd1);
    chk("R7 data c4", 32'(rdata), 32'(d));
    chk("R11 busy c4", 32'(busy), 32'd1);
    chk("R6 hi hold c4", 32'(addr_hi), 32'(exp_hi(a)));
    chk("R6 lanes off c4", 32'(bl_n), 32'(exp_bl('0)));
    chk("R5 released c4", 32'(ad_oe), 32'd0);
    @(negedge clk); // cycle 5
    chk("R7 valid pulse ends", 32'(rvalid), 32'd0);
    chk("R10 no re-accept", 32'(ce_n), 32'd1);
    chk_idle(d);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk_idle(d);
      chk("R7 no valid idle", 32'(rvalid), 32'd0);
    end
  endtask

  initial begin
    mem_data = '0;
    repeat (2) @(negedge clk);
    chk("R9 ce reset", 32'(ce_n), 32'd1);
    chk("R9 oe reset", 32'(oe_n), 32'd1);
    chk("R9 adv reset", 32'(adv_n), 32'd1);
    chk("R9 we reset", 32'(we_n), 32'd1);
    chk("R9 lanes reset", 32'(bl_n), 32'(exp_bl('0)));
    chk("R9 drive reset", 32'(ad_oe), 32'd0);
    chk("R9 busy reset", 32'(busy), 32'd0);
    chk("R9 valid reset", 32'(rvalid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ce after reset", 32'(ce_n), 32'd1);
    chk("R9 busy after reset", 32'(busy), 32'd0);

    do_read('0, 2'b00, 16'h0000, 1'b0, 0);
    do_read({ADDR_W{1'b1}}, 2'b11, 16'hffff, 1'b0, 1);
    do_read(26'h2a5_5a5a, 2'b01, 16'h1234, 1'b1, 0);
    do_read(26'h15a_a5a5, 2'b10, 16'hbeef, 1'b1, 2);

    void'($urandom(32'd1234));
    for (int k = 0; k < 60; k++) begin
      do_read(ADDR_W'($urandom()), BE_W'($urandom()), DATA_W'($urandom()),
              1'($urandom()), int'($urandom() % 4));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule